// File: doc/BRIEF.md
# Register Scoreboard with Bypass Selection

This block tracks the availability of every architectural register for the register-read stage of an in-order pipeline. It holds one busy flag per register. An issue port raises the flag of a destination register when a writing instruction leaves register read. A writeback port lowers the flag once the register file has been updated.

A query port takes the two source register indices of the instruction that is waiting in register read, together with the register file read data for those indices. For each source, the block decides whether the operand is usable. A free register takes the register file data. A busy register can still be used if one of several forwarding sources currently carries its value. The block returns the two resolved operand values and one stall flag.

Each forwarding source carries a valid flag, a register index and a value. When several sources match, the earliest pipeline stage wins. Register 0 is hard-wired to zero. The register file, decode and the pipeline queues lie outside this block.

Top module: `operand_scoreboard`

## Requirements
- R1: After reset every register is free, so any pair of sources resolves without stall using the register file data.
- R2: An issue request (`iss_en` high) with a nonzero destination index marks that register busy from the next clock edge on.
- R3: A writeback request (`wb_en` high) marks its register free from the next clock edge on. The query in the same cycle still sees the old flag.
- R4: When issue and writeback name the same register in the same cycle, the register is busy after the edge (set wins over clear).
- R5: When issue and writeback name different registers in the same cycle, both updates take effect after the edge.
- R6: Register 0 is never marked busy. A source index of 0 always resolves as ready with operand value 0, regardless of register file data or forwarding sources.
- R7: A source whose register is free resolves as ready with the register file data, even when a valid forwarding source carries the same index with a different value.
- R8: A source whose register is busy resolves as ready when a forwarding source is valid and its index equals the source index. Its value is then that source's value. Forwarding source k occupies bits [k*5 +: 5] of `byp_idx` and bits [k*32 +: 32] of `byp_data`. Source 0 is the earliest stage and has the highest priority, then 1, then 2.
- R9: A busy source with no forwarding source that is both valid and index-matching resolves as not ready.
- R10: Each source resolves independently on `a_ready` and `b_ready`. `stall` is high exactly when at least one of the two is not ready.
- R11: In a cycle with neither issue nor writeback, the busy state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_en | input | 1 | Writing instruction leaves register read |
| iss_rd | input | 5 | Destination index to mark busy |
| wb_en | input | 1 | Writeback updates a register |
| wb_rd | input | 5 | Index to mark free |
| src_a_idx | input | 5 | First source index |
| src_b_idx | input | 5 | Second source index |
| rf_a_data | input | 32 | Register file data for the first source |
| rf_b_data | input | 32 | Register file data for the second source |
| byp_valid | input | 3 | Valid flag per forwarding source, bit 0 earliest stage |
| byp_idx | input | 15 | Register index per forwarding source, packed |
| byp_data | input | 96 | Value per forwarding source, packed |
| stall | output | 1 | Instruction cannot leave register read |
| a_ready | output | 1 | First source resolved |
| b_ready | output | 1 | Second source resolved |
| opnd_a | output | 32 | Resolved first operand |
| opnd_b | output | 32 | Resolved second operand |

## Verification
The bench builds the block with its defaults: 32 registers, 32-bit data and three forwarding sources. Three sources are enough to make all three match at once, so the full priority order can be observed, and to mix valid-but-mismatched with invalid-but-matching entries. Random traffic limited to the low registers keeps many registers busy at the same time, so set/clear collisions and busy operands that are rescued by forwarding occur often.

// File: rtl/opsb_pkg.sv
package opsb_pkg;
    parameter int SB_IDX_W  = 5;
    parameter int SB_DATA_W = 32;
    localparam int SB_NREGS = 1 << SB_IDX_W;

    typedef logic [SB_IDX_W-1:0]  reg_idx_t;
    typedef logic [SB_DATA_W-1:0] word_t;

    typedef struct packed {
        logic     valid;
        reg_idx_t idx;
        word_t    value;
    } fwd_src_t;

    typedef struct packed {
        logic  hit;
        word_t value;
    } fwd_pick_t;

    typedef struct packed {
        logic  ready;
        word_t value;
    } opnd_res_t;

    typedef enum logic [1:0] {
        OPND_ZERO = 2'd0,
        OPND_RF   = 2'd1,
        OPND_FWD  = 2'd2,
        OPND_WAIT = 2'd3
    } opnd_src_e;

    function automatic logic is_zero_reg(reg_idx_t r);
        return r == '0;
    endfunction

    function automatic logic fwd_matches(fwd_src_t s, reg_idx_t r);
        return s.valid && (s.idx == r);
    endfunction
endpackage

// File: rtl/opsb_busy_table.sv
module opsb_busy_table
    import opsb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                set_en,
    input  reg_idx_t            set_idx,
    input  logic                clr_en,
    input  reg_idx_t            clr_idx,
    output logic [SB_NREGS-1:0] busy_q
);
    for (genvar g = 0; g < SB_NREGS; g++) begin : g_flag
        if (g == 0) begin : g_hard_zero
            assign busy_q[g] = 1'b0;
        end else begin : g_tracked
            logic set_hit, clr_hit, flag_q;
            assign set_hit = set_en && (set_idx == reg_idx_t'(g));
            assign clr_hit = clr_en && (clr_idx == reg_idx_t'(g));
            always_ff @(posedge clk) begin
                if (rst)
                    flag_q <= 1'b0;
                else if (set_hit)
                    flag_q <= 1'b1;
                else if (clr_hit)
                    flag_q <= 1'b0;
            end
            assign busy_q[g] = flag_q;
        end
    end
endmodule

// File: rtl/opsb_fwd_select.sv
module opsb_fwd_select
    import opsb_pkg::*;
#(
    parameter int NUM_BYP = 3
) (
    input  reg_idx_t                     want_idx,
    input  logic [NUM_BYP-1:0]           byp_valid,
    input  logic [NUM_BYP*SB_IDX_W-1:0]  byp_idx,
    input  logic [NUM_BYP*SB_DATA_W-1:0] byp_data,
    output fwd_pick_t                    pick
);
    fwd_src_t src [NUM_BYP];

    for (genvar k = 0; k < NUM_BYP; k++) begin : g_unpack
        assign src[k].valid = byp_valid[k];
        assign src[k].idx   = byp_idx[k*SB_IDX_W +: SB_IDX_W];
        assign src[k].value = byp_data[k*SB_DATA_W +: SB_DATA_W];
    end

    // Scan from the latest stage down so that the earliest match is left standing.
    always_comb begin
        pick = '0;
        for (int k = NUM_BYP - 1; k >= 0; k--) begin
            if (fwd_matches(src[k], want_idx)) begin
                pick.hit   = 1'b1;
                pick.value = src[k].value;
            end
        end
    end
endmodule

// File: rtl/opsb_opnd_resolve.sv
module opsb_opnd_resolve
    import opsb_pkg::*;
(
    input  reg_idx_t            idx,
    input  logic [SB_NREGS-1:0] busy_vec,
    input  word_t               rf_data,
    input  fwd_pick_t           fwd,
    output opnd_res_t           res
);
    opnd_src_e how;

    always_comb begin
        if (is_zero_reg(idx))
            how = OPND_ZERO;
        else if (!busy_vec[idx])
            how = OPND_RF;
        else if (fwd.hit)
            how = OPND_FWD;
        else
            how = OPND_WAIT;
    end

    always_comb begin
        unique case (how)
            OPND_ZERO: res = '{ready: 1'b1, value: '0};
            OPND_RF:   res = '{ready: 1'b1, value: rf_data};
            OPND_FWD:  res = '{ready: 1'b1, value: fwd.value};
            default:   res = '{ready: 1'b0, value: '0};
        endcase
    end
endmodule

// File: rtl/operand_scoreboard.sv
module operand_scoreboard
    import opsb_pkg::*;
#(
    parameter int NUM_BYP = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         iss_en,
    input  logic [SB_IDX_W-1:0]          iss_rd,
    input  logic                         wb_en,
    input  logic [SB_IDX_W-1:0]          wb_rd,
    input  logic [SB_IDX_W-1:0]          src_a_idx,
    input  logic [SB_IDX_W-1:0]          src_b_idx,
    input  logic [SB_DATA_W-1:0]         rf_a_data,
    input  logic [SB_DATA_W-1:0]         rf_b_data,
    input  logic [NUM_BYP-1:0]           byp_valid,
    input  logic [NUM_BYP*SB_IDX_W-1:0]  byp_idx,
    input  logic [NUM_BYP*SB_DATA_W-1:0] byp_data,
    output logic                         stall,
    output logic                         a_ready,
    output logic                         b_ready,
    output logic [SB_DATA_W-1:0]         opnd_a,
    output logic [SB_DATA_W-1:0]         opnd_b
);
    localparam int NUM_SRC = 2;

    logic [SB_NREGS-1:0] busy_q;
    reg_idx_t            q_idx  [NUM_SRC];
    word_t               q_data [NUM_SRC];
    fwd_pick_t           q_fwd  [NUM_SRC];
    opnd_res_t           q_res  [NUM_SRC];

    opsb_busy_table u_table (
        .clk     (clk),
        .rst     (rst),
        .set_en  (iss_en),
        .set_idx (iss_rd),
        .clr_en  (wb_en),
        .clr_idx (wb_rd),
        .busy_q  (busy_q)
    );

    assign q_idx[0]  = src_a_idx;
    assign q_idx[1]  = src_b_idx;
    assign q_data[0] = rf_a_data;
    assign q_data[1] = rf_b_data;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        opsb_fwd_select #(.NUM_BYP(NUM_BYP)) u_fwd (
            .want_idx  (q_idx[s]),
            .byp_valid (byp_valid),
            .byp_idx   (byp_idx),
            .byp_data  (byp_data),
            .pick      (q_fwd[s])
        );
        opsb_opnd_resolve u_res (
            .idx      (q_idx[s]),
            .busy_vec (busy_q),
            .rf_data  (q_data[s]),
            .fwd      (q_fwd[s]),
            .res      (q_res[s])
        );
    end

    assign a_ready = q_res[0].ready;
    assign b_ready = q_res[1].ready;
    assign opnd_a  = q_res[0].value;
    assign opnd_b  = q_res[1].value;
    assign stall   = !(q_res[0].ready && q_res[1].ready);
endmodule

// File: rtl/opsb_checker.sv
module opsb_checker
    import opsb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                iss_en,
    input reg_idx_t            iss_rd,
    input logic                wb_en,
    input reg_idx_t            wb_rd,
    input reg_idx_t            src_a_idx,
    input word_t               rf_a_data,
    input logic                a_ready,
    input word_t               opnd_a,
    input logic [SB_NREGS-1:0] busy_q
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy_q == '0));

    a_r2_issue_sets: assert property (@(posedge clk) disable iff (rst)
        (iss_en && iss_rd != '0) |=> busy_q[$past(iss_rd)]);

    a_r3_wb_clears: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !(iss_en && iss_rd == wb_rd)) |=> !busy_q[$past(wb_rd)]);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
        (iss_en && wb_en && iss_rd == wb_rd && iss_rd != '0) |=> busy_q[$past(iss_rd)]);

    a_r6_zero_never_busy: assert property (@(posedge clk) disable iff (rst)
        iss_en |=> !busy_q[0]);

    a_r6_zero_value: assert property (@(posedge clk) disable iff (rst)
        (src_a_idx == '0) |-> (a_ready && opnd_a == '0));

    a_r7_free_uses_rf: assert property (@(posedge clk) disable iff (rst)
        (src_a_idx != '0 && !busy_q[src_a_idx]) |-> (a_ready && opnd_a == rf_a_data));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!iss_en && !wb_en) |=> $stable(busy_q));
endmodule

bind operand_scoreboard opsb_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .iss_en    (iss_en),
    .iss_rd    (iss_rd),
    .wb_en     (wb_en),
    .wb_rd     (wb_rd),
    .src_a_idx (src_a_idx),
    .rf_a_data (rf_a_data),
    .a_ready   (a_ready),
    .opnd_a    (opnd_a),
    .busy_q    (busy_q)
);

// File: tb/operand_scoreboard_tb_top.sv
module operand_scoreboard_tb_top;
    localparam int NB = 3;
    localparam int IW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iss_en = 0, wb_en = 0;
    logic [IW-1:0] iss_rd = 0, wb_rd = 0, src_a_idx = 0, src_b_idx = 0;
    logic [DW-1:0] rf_a_data = 0, rf_b_data = 0;
    logic [NB-1:0] byp_valid = 0;
    logic [NB*IW-1:0] byp_idx = 0;
    logic [NB*DW-1:0] byp_data = 0;
    logic stall, a_ready, b_ready;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_checks = 0;
    int n_fail = 0;
    bit busy_m [32];

    always #4 clk = ~clk;

    operand_scoreboard #(.NUM_BYP(NB)) dut_i (
        .clk(clk), .rst(rst), .iss_en(iss_en), .iss_rd(iss_rd),
        .wb_en(wb_en), .wb_rd(wb_rd), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .byp_valid(byp_valid),
        .byp_idx(byp_idx), .byp_data(byp_data), .stall(stall),
        .a_ready(a_ready), .b_ready(b_ready), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_fwd(int k, bit v, logic [IW-1:0] r, logic [DW-1:0] d);
        byp_valid[k] = v;
        byp_idx[k*IW +: IW] = r;
        byp_data[k*DW +: DW] = d;
    endtask

    // Reference: walk the forwarding list in stage order, first match taken.
    task automatic expect_opnd(logic [IW-1:0] r, logic [DW-1:0] rf,
                               output bit rdy, output logic [DW-1:0] v, output string why);
        rdy = 0; v = 0; why = "R9";
        if (r == 0) begin rdy = 1; v = 0; why = "R6"; return; end
        if (!busy_m[r]) begin rdy = 1; v = rf; why = "R7"; return; end
        for (int k = 0; k < NB; k++) begin
            if (byp_valid[k] && byp_idx[k*IW +: IW] == r) begin
                rdy = 1; v = byp_data[k*DW +: DW]; why = "R8"; return;
            end
        end
    endtask

    // Drive at negedge, compare before the edge, then advance the model.
    task automatic step(string tag, bit ie, logic [IW-1:0] ird, bit we, logic [IW-1:0] wrd,
                        logic [IW-1:0] sa, logic [IW-1:0] sb,
                        logic [DW-1:0] ra, logic [DW-1:0] rb);
        bit ra_ok, rb_ok;
        logic [DW-1:0] va, vb;
        string wa, wb;
        iss_en = ie; iss_rd = ird; wb_en = we; wb_rd = wrd;
        src_a_idx = sa; src_b_idx = sb; rf_a_data = ra; rf_b_data = rb;
        #1;
        expect_opnd(sa, ra, ra_ok, va, wa);
        expect_opnd(sb, rb, rb_ok, vb, wb);
        check({tag, "/", wa, " a_ready"}, a_ready, ra_ok);
        check({tag, "/", wb, " b_ready"}, b_ready, rb_ok);
        check({tag, "/R10 stall"}, stall, !(ra_ok && rb_ok));
        if (ra_ok) check({tag, "/", wa, " opnd_a"}, opnd_a, va);
        if (rb_ok) check({tag, "/", wb, " opnd_b"}, opnd_b, vb);
        @(posedge clk);
        if (we && wrd != 0) busy_m[wrd] = 0;
        if (ie && ird != 0) busy_m[ird] = 1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) busy_m[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: everything free after reset
        for (int i = 0; i < 32; i += 2)
            step("R1", 0, 0, 0, 0, IW'(i), IW'(i + 1), 32'hA000_0000 + i, 32'hB000_0000 + i);

        // R2: issue r5, then r5 stalls without forwarding
        step("R2", 1, 5, 0, 0, 1, 2, 32'h11, 32'h22);
        step("R2", 0, 0, 0, 0, 5, 2, 32'h55, 32'h22);
        step("R10", 0, 0, 0, 0, 2, 5, 32'h22, 32'h55);

        // R8: forwarding rescues r5; priority across three matches
        set_fwd(2, 1, 5, 32'hC2C2_C2C2);
        step("R8", 0, 0, 0, 0, 5, 5, 32'h55, 32'h55);
        set_fwd(1, 1, 5, 32'hC1C1_C1C1);
        step("R8", 0, 0, 0, 0, 5, 3, 32'h55, 32'h33);
        set_fwd(0, 1, 5, 32'hC0C0_C0C0);
        step("R8", 0, 0, 0, 0, 3, 5, 32'h33, 32'h55);

        // R9: invalid but matching, valid but mismatched
        set_fwd(0, 0, 5, 32'hDEAD_0000);
        set_fwd(1, 1, 6, 32'hDEAD_0001);
        set_fwd(2, 0, 5, 32'hDEAD_0002);
        step("R9", 0, 0, 0, 0, 5, 1, 32'h55, 32'h11);

        // R7: free operand ignores a matching forwarding value
        set_fwd(1, 1, 4, 32'hBAD0_BAD0);
        step("R7", 0, 0, 0, 0, 4, 5, 32'h4444_4444, 32'h55);
        byp_valid = '0;

        // R3: writeback frees r5; same-cycle query still sees busy
        step("R3", 0, 0, 1, 5, 5, 0, 32'h55, 32'h0);
        step("R3", 0, 0, 0, 0, 5, 5, 32'h5555, 32'h5555);

        // R4: set and clear of r7 in one cycle leaves it busy
        step("R4", 1, 7, 1, 7, 7, 1, 32'h77, 32'h11);
        step("R4", 0, 0, 0, 0, 7, 1, 32'h77, 32'h11);

        // R5: set r9 while clearing r7
        step("R5", 1, 9, 1, 7, 9, 7, 32'h99, 32'h77);
        step("R5", 0, 0, 0, 0, 9, 7, 32'h99, 32'h77);

        // R6: register 0 cannot go busy and reads zero even with data and forwarding
        set_fwd(0, 1, 0, 32'hFFFF_FFFF);
        step("R6", 1, 0, 0, 0, 0, 0, 32'h1234_5678, 32'h8765_4321);
        step("R6", 0, 0, 0, 0, 0, 9, 32'hFFFF_0000, 32'h99);
        byp_valid = '0;

        // R11: idle cycles keep r9 busy and r7 free
        for (int i = 0; i < 4; i++)
            step("R11", 0, 0, 0, 0, 9, 7, 32'h99, 32'h77);

        // R10: random traffic over the low registers
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < NB; k++)
                set_fwd(k, 1'($urandom_range(0, 1)), IW'($urandom_range(0, 7)), $urandom);
            step("R10", 1'($urandom_range(0, 1)), IW'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), IW'($urandom_range(0, 7)),
                 IW'($urandom_range(0, 7)), IW'($urandom_range(0, 7)), $urandom, $urandom);
        end
        finish_run();
    end
endmodule